// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block gathers the interrupt sources that are local to a cluster of four cores and decides, for each source, which core's IRQ line or FIQ line it raises. The sources are four timer levels per core, four mailbox levels per core, one peripheral interrupt shared by the cluster, one performance-monitor level per core, a bus-error level and a local-timer level. Every source is level sensitive: nothing is latched inside the block, so a source stays visible until it drops at its origin.

Software programs the routing through a small word-addressed register bus. Each source type has its own style of routing. Timers are enabled per core, with one IRQ bit and one FIQ bit for each timer. The shared peripheral interrupt is steered to exactly one core by a 2-bit core number for IRQ and another for FIQ, each with its own enable. The performance-monitor enables live behind a write-1-to-set address and a write-1-to-clear address, so one core can change its own bits without a read-modify-write race against the others. Each core can also read a pending word that shows every source level for that core at a fixed bit position.

Top module: `lirq_router`

## Requirements
- R1: After a synchronous active-low reset every configuration register reads zero and, with all sources low, every `core_irq` and `core_fiq` bit is 0.
- R2: The control word at 0x00 and the prescaler word at 0x08 store all 32 written bits and read back unchanged (0x80000000 in the prescaler selects the 19.2 MHz timer rate and is only stored).
- R3: The timer configuration word of core n is at 0x40+4n; bit t enables the IRQ of timer t and bit t+4 enables its FIQ; bits 31:8 read as zero; `core_irq`/`core_fiq` reflect a change of a source or of a register one clock after it.
- R4: Writing zero to a core's timer configuration word masks all four timers of that core on both lines.
- R5: The shared routing word at 0x0C holds the IRQ target core in bits 1:0, the FIQ target core in bits 3:2, an IRQ enable in bit 4 and a FIQ enable in bit 5; the shared interrupt raises at most one core's IRQ and at most one core's FIQ.
- R6: Writing 0x10 ORs the written 1 bits into the performance-monitor enables and writing 0x14 clears the written 1 bits; bit n enables core n's IRQ and bit n+4 its FIQ; a read of either address returns the enable byte.
- R7: The pending word of core n at 0x60+4n shows the live source levels: bits 3:0 that core's timers 0 to 3, bits 7:4 its mailboxes 0 to 3, bit 8 the shared interrupt, bit 9 its performance monitor, bit 10 bus error, bit 11 local timer, bits 31:12 zero; bits 10 and 11 drive no output line.
- R8: Any high mailbox level of core n raises `core_irq[n]` and never `core_fiq`.
- R9: A read of an address that is not a register returns zero; a write to such an address, or to a pending word, changes no register.
- R10: Read data and `bus_rvalid` appear one clock after the read request, back-to-back reads are served in order, and `bus_rvalid` is low in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one clock after the request |
| timer_lvl | input | 16 | Timer levels, bit 4n+t is timer t of core n |
| mbox_lvl | input | 16 | Mailbox levels, bit 4n+m is mailbox m of core n |
| periph_lvl | input | 1 | Shared peripheral interrupt level |
| perf_lvl | input | 4 | Performance-monitor level per core |
| berr_lvl | input | 1 | Bus error interrupt level |
| ltmr_lvl | input | 1 | Local timer interrupt level |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
The assertions check on every cycle the set/clear arithmetic of the performance-monitor enables, that a zero write empties a timer configuration, that the shared interrupt alone never raises two cores, that a timer-free and monitor-free FIQ state stays quiet, that mailbox levels always reach the IRQ line, and the read timing and zero data of undefined addresses. Only the bench scenarios show that each field sits at its stated bit and address: the per-timer IRQ/FIQ split, the exact target core of the shared route, the pending word layout for several source patterns, and that writes to pending or unmapped words leave every stored value alone.

// File: rtl/lirq_pkg.sv
// Package: shared constants and types of the local interrupt router.
// Assumes a cluster of at most four cores so that every per-core word
// fits in the 0x40 and 0x60 windows and a core number fits in two bits.
package lirq_pkg;

    localparam int CORE_SEL_W = 2;

    // Word addresses of the register bus
    localparam int ADDR_CTRL  = 'h00;
    localparam int ADDR_PRESC = 'h08;
    localparam int ADDR_ROUTE = 'h0C;
    localparam int ADDR_PSET  = 'h10;
    localparam int ADDR_PCLR  = 'h14;
    localparam int ADDR_TCFG  = 'h40;
    localparam int ADDR_PEND  = 'h60;

    // Bit positions inside a pending word (timers start at bit 0)
    localparam int PB_MBOX   = 4;
    localparam int PB_PERIPH = 8;
    localparam int PB_PERF   = 9;
    localparam int PB_BERR   = 10;
    localparam int PB_LTMR   = 11;

    // Shared peripheral routing word, bit 0 at the right
    typedef struct packed {
        logic                  fiq_en;
        logic                  irq_en;
        logic [CORE_SEL_W-1:0] fiq_core;
        logic [CORE_SEL_W-1:0] irq_core;
    } route_t;

endpackage

// File: rtl/lirq_pend_pack.sv
// Module: lirq_pend_pack
// Builds the pending word of one core from live source levels.
// Assumes NTMR <= PB_MBOX and PB_MBOX + NMBX <= PB_PERIPH, so that the
// fixed bit positions of the package do not overlap.
module lirq_pend_pack
    import lirq_pkg::*;
#(
    parameter int NTMR = 4,
    parameter int NMBX = 4,
    parameter int DW   = 32
) (
    input  logic [NTMR-1:0] timer_lvl,
    input  logic [NMBX-1:0] mbox_lvl,
    input  logic            periph_lvl,
    input  logic            perf_lvl,
    input  logic            berr_lvl,
    input  logic            ltmr_lvl,
    output logic [DW-1:0]   pend_word
);

    // Place every source level at its fixed position, the rest stays zero
    always_comb begin
        pend_word                   = '0;
        pend_word[NTMR-1:0]         = timer_lvl;
        pend_word[PB_MBOX +: NMBX]  = mbox_lvl;
        pend_word[PB_PERIPH]        = periph_lvl;
        pend_word[PB_PERF]          = perf_lvl;
        pend_word[PB_BERR]          = berr_lvl;
        pend_word[PB_LTMR]          = ltmr_lvl;
    end

endmodule

// File: rtl/lirq_core_route.sv
// Module: lirq_core_route
// Combines the sources that can reach one core into that core's IRQ and
// FIQ lines and registers both lines. Assumes the routing values it gets
// are already stored registers, so the output is one clock behind them.
module lirq_core_route
    import lirq_pkg::*;
#(
    parameter int CORE_ID = 0,
    parameter int NTMR    = 4,
    parameter int NMBX    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTMR-1:0]   timer_lvl,
    input  logic [2*NTMR-1:0] tcfg,
    input  logic [NMBX-1:0]   mbox_lvl,
    input  logic              periph_lvl,
    input  route_t            route,
    input  logic              perf_lvl,
    input  logic              perf_irq_en,
    input  logic              perf_fiq_en,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam logic [CORE_SEL_W-1:0] MY_SEL = CORE_SEL_W'(CORE_ID);

    logic tmr_irq, tmr_fiq;
    logic per_irq, per_fiq;
    logic pmu_irq, pmu_fiq;
    logic mbx_irq;

    // Per-source qualification against this core's enables
    always_comb begin
        tmr_irq = |(timer_lvl & tcfg[NTMR-1:0]);
        tmr_fiq = |(timer_lvl & tcfg[2*NTMR-1:NTMR]);
        per_irq = periph_lvl && route.irq_en && (route.irq_core == MY_SEL);
        per_fiq = periph_lvl && route.fiq_en && (route.fiq_core == MY_SEL);
        pmu_irq = perf_lvl && perf_irq_en;
        pmu_fiq = perf_lvl && perf_fiq_en;
        mbx_irq = |mbox_lvl;
    end

    // Register the two output lines of the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= tmr_irq | per_irq | pmu_irq | mbx_irq;
            fiq_o <= tmr_fiq | per_fiq | pmu_fiq;
        end
    end

endmodule

// File: rtl/lirq_regs.sv
// Module: lirq_regs
// Address decode, configuration storage and read path of the router.
// One access per cycle; writes land at the clock edge that sees them,
// read data is registered and comes one clock after the request.
// Assumes NCORE <= 4 and 2*NTMR, 2*NCORE, $bits(route_t) <= DW.
module lirq_regs
    import lirq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NTMR  = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic                  bus_rvalid,
    input  logic [NCORE*DW-1:0]   pend_word,
    output logic [NCORE*2*NTMR-1:0] tcfg_q,
    output route_t                route_q,
    output logic [2*NCORE-1:0]    perf_en_q
);

    localparam int TW = 2 * NTMR;
    localparam int PW = 2 * NCORE;
    localparam int RW = $bits(route_t);

    logic            wr_en, rd_en;
    logic            hit_ctrl, hit_presc, hit_route, hit_pset, hit_pclr;
    logic [NCORE-1:0] hit_tcfg, hit_pend;
    logic [DW-1:0]   ctrl_q, presc_q;
    logic [DW-1:0]   rd_next;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    // Decode of the single-word registers
    always_comb begin
        hit_ctrl  = (bus_addr == AW'(ADDR_CTRL));
        hit_presc = (bus_addr == AW'(ADDR_PRESC));
        hit_route = (bus_addr == AW'(ADDR_ROUTE));
        hit_pset  = (bus_addr == AW'(ADDR_PSET));
        hit_pclr  = (bus_addr == AW'(ADDR_PCLR));
    end

    // Decode of the per-core words, one comparator pair per core
    for (genvar c = 0; c < NCORE; c++) begin : g_dec
        assign hit_tcfg[c] = (bus_addr == AW'(ADDR_TCFG + 4 * c));
        assign hit_pend[c] = (bus_addr == AW'(ADDR_PEND + 4 * c));
    end

    // Configuration storage with its three write styles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            presc_q   <= '0;
            route_q   <= '0;
            perf_en_q <= '0;
            tcfg_q    <= '0;
        end else if (wr_en) begin
            if (hit_ctrl)  ctrl_q    <= bus_wdata;
            if (hit_presc) presc_q   <= bus_wdata;
            if (hit_route) route_q   <= route_t'(bus_wdata[RW-1:0]);
            if (hit_pset)  perf_en_q <= perf_en_q | bus_wdata[PW-1:0];
            if (hit_pclr)  perf_en_q <= perf_en_q & ~bus_wdata[PW-1:0];
            for (int c = 0; c < NCORE; c++) begin
                if (hit_tcfg[c]) tcfg_q[c*TW +: TW] <= bus_wdata[TW-1:0];
            end
        end
    end

    // Read multiplexer, zero for any address that is not a register
    always_comb begin
        rd_next = '0;
        if (hit_ctrl)             rd_next = ctrl_q;
        if (hit_presc)            rd_next = presc_q;
        if (hit_route)            rd_next = DW'(route_q);
        if (hit_pset || hit_pclr) rd_next = DW'(perf_en_q);
        for (int c = 0; c < NCORE; c++) begin
            if (hit_tcfg[c]) rd_next = DW'(tcfg_q[c*TW +: TW]);
            if (hit_pend[c]) rd_next = pend_word[c*DW +: DW];
        end
    end

    // Registered read return with its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/lirq_router.sv
// Module: lirq_router (top)
// Local interrupt router for a small core cluster: a register block and
// one pending packer plus one output combiner per core. Assumes all
// sources are levels already synchronous to clk.
module lirq_router
    import lirq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NTMR  = 4,
    parameter int NMBX  = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic                  bus_rvalid,
    input  logic [NCORE*NTMR-1:0] timer_lvl,
    input  logic [NCORE*NMBX-1:0] mbox_lvl,
    input  logic                  periph_lvl,
    input  logic [NCORE-1:0]      perf_lvl,
    input  logic                  berr_lvl,
    input  logic                  ltmr_lvl,
    output logic [NCORE-1:0]      core_irq,
    output logic [NCORE-1:0]      core_fiq
);

    localparam int TW = 2 * NTMR;

    logic [NCORE*DW-1:0]  pend_word;
    logic [NCORE*TW-1:0]  tcfg_q;
    route_t               route_q;
    logic [2*NCORE-1:0]   perf_en_q;

    lirq_regs #(
        .NCORE (NCORE),
        .NTMR  (NTMR),
        .AW    (AW),
        .DW    (DW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pend_word  (pend_word),
        .tcfg_q     (tcfg_q),
        .route_q    (route_q),
        .perf_en_q  (perf_en_q)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        lirq_pend_pack #(
            .NTMR (NTMR),
            .NMBX (NMBX),
            .DW   (DW)
        ) u_pend (
            .timer_lvl  (timer_lvl[c*NTMR +: NTMR]),
            .mbox_lvl   (mbox_lvl[c*NMBX +: NMBX]),
            .periph_lvl (periph_lvl),
            .perf_lvl   (perf_lvl[c]),
            .berr_lvl   (berr_lvl),
            .ltmr_lvl   (ltmr_lvl),
            .pend_word  (pend_word[c*DW +: DW])
        );

        lirq_core_route #(
            .CORE_ID (c),
            .NTMR    (NTMR),
            .NMBX    (NMBX)
        ) u_route (
            .clk         (clk),
            .rst_n       (rst_n),
            .timer_lvl   (timer_lvl[c*NTMR +: NTMR]),
            .tcfg        (tcfg_q[c*TW +: TW]),
            .mbox_lvl    (mbox_lvl[c*NMBX +: NMBX]),
            .periph_lvl  (periph_lvl),
            .route       (route_q),
            .perf_lvl    (perf_lvl[c]),
            .perf_irq_en (perf_en_q[c]),
            .perf_fiq_en (perf_en_q[c+NCORE]),
            .irq_o       (core_irq[c]),
            .fiq_o       (core_fiq[c])
        );
    end

endmodule

// File: rtl/lirq_router_chk.sv
// Module: lirq_router_chk
// Assertion checker bound to lirq_router. Observes the bus, the source
// levels, the output lines and the stored enables; drives nothing.
module lirq_router_chk
    import lirq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NTMR  = 4,
    parameter int NMBX  = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_sel,
    input logic                    bus_wr,
    input logic [AW-1:0]           bus_addr,
    input logic [DW-1:0]           bus_wdata,
    input logic [DW-1:0]           bus_rdata,
    input logic                    bus_rvalid,
    input logic [NCORE*NTMR-1:0]   timer_lvl,
    input logic [NCORE*NMBX-1:0]   mbox_lvl,
    input logic                    periph_lvl,
    input logic [NCORE-1:0]        perf_lvl,
    input logic [NCORE-1:0]        core_irq,
    input logic [NCORE-1:0]        core_fiq,
    input logic [NCORE*2*NTMR-1:0] tcfg_q,
    input logic [2*NCORE-1:0]      perf_en_q
);

    localparam int TW = 2 * NTMR;
    localparam int PW = 2 * NCORE;

    // Address map as seen from outside
    function automatic logic known_addr(input logic [AW-1:0] a);
        known_addr = (a == AW'(ADDR_CTRL)) || (a == AW'(ADDR_PRESC)) ||
                     (a == AW'(ADDR_ROUTE)) || (a == AW'(ADDR_PSET)) ||
                     (a == AW'(ADDR_PCLR));
        for (int c = 0; c < NCORE; c++) begin
            if (a == AW'(ADDR_TCFG + 4 * c) || a == AW'(ADDR_PEND + 4 * c))
                known_addr = 1'b1;
        end
    endfunction

    logic rd_req, tfiq_any;
    assign rd_req = bus_sel && !bus_wr;

    // Any timer FIQ enable anywhere in the cluster
    always_comb begin
        tfiq_any = 1'b0;
        for (int c = 0; c < NCORE; c++)
            tfiq_any = tfiq_any | (|tcfg_q[c*TW+NTMR +: NTMR]);
    end

    p_perf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(ADDR_PSET)) |=>
        (perf_en_q == ($past(perf_en_q) | $past(bus_wdata[PW-1:0]))))
        else $error("perf enable set mismatch");

    p_perf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(ADDR_PCLR)) |=>
        (perf_en_q == ($past(perf_en_q) & ~$past(bus_wdata[PW-1:0]))))
        else $error("perf enable clear mismatch");

    p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid)
        else $error("read data missing");

    p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid)
        else $error("read data without request");

    p_undef_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !known_addr(bus_addr)) |=> (bus_rdata == '0))
        else $error("undefined address read non-zero");

    p_shared_irq_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(timer_lvl == '0 && mbox_lvl == '0 && perf_lvl == '0))
        |-> $onehot0(core_irq))
        else $error("shared interrupt on several IRQ lines");

    p_shared_fiq_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(timer_lvl == '0 && perf_lvl == '0))
        |-> $onehot0(core_fiq))
        else $error("shared interrupt on several FIQ lines");

    p_fiq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!tfiq_any && perf_lvl == '0 && !periph_lvl))
        |-> (core_fiq == '0))
        else $error("FIQ without an enabled FIQ source");

    for (genvar c = 0; c < NCORE; c++) begin : g_core_chk
        p_tcfg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == AW'(ADDR_TCFG + 4 * c) && bus_wdata == '0)
            |=> (tcfg_q[c*TW +: TW] == '0))
            else $error("timer config not cleared");

        p_mbox_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mbox_lvl[c*NMBX +: NMBX] != '0)) |-> core_irq[c])
            else $error("mailbox level did not raise IRQ");
    end

endmodule

bind lirq_router lirq_router_chk #(
    .NCORE (NCORE),
    .NTMR  (NTMR),
    .NMBX  (NMBX),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .timer_lvl  (timer_lvl),
    .mbox_lvl   (mbox_lvl),
    .periph_lvl (periph_lvl),
    .perf_lvl   (perf_lvl),
    .core_irq   (core_irq),
    .core_fiq   (core_fiq),
    .tcfg_q     (tcfg_q),
    .perf_en_q  (perf_en_q)
);

// File: tb/lirq_router_bench.sv
// Bench for lirq_router: a driver pushes expected read data into a queue,
// a monitor pops and compares on every returned read; output lines are
// compared directly. Inputs change and outputs are sampled at negedge.
module lirq_router_bench;

    localparam int NCORE = 4;
    localparam int NTMR  = 4;
    localparam int NMBX  = 4;
    localparam int AW    = 8;
    localparam int DW    = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  rst_n;
    logic                  bus_sel, bus_wr;
    logic [AW-1:0]         bus_addr;
    logic [DW-1:0]         bus_wdata;
    logic [DW-1:0]         bus_rdata;
    logic                  bus_rvalid;
    logic [NCORE*NTMR-1:0] timer_lvl;
    logic [NCORE*NMBX-1:0] mbox_lvl;
    logic                  periph_lvl;
    logic [NCORE-1:0]      perf_lvl;
    logic                  berr_lvl, ltmr_lvl;
    logic [NCORE-1:0]      core_irq, core_fiq;

    lirq_router #(
        .NCORE (NCORE), .NTMR (NTMR), .NMBX (NMBX), .AW (AW), .DW (DW)
    ) u_lirq_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .timer_lvl  (timer_lvl),
        .mbox_lvl   (mbox_lvl),
        .periph_lvl (periph_lvl),
        .perf_lvl   (perf_lvl),
        .berr_lvl   (berr_lvl),
        .ltmr_lvl   (ltmr_lvl),
        .core_irq   (core_irq),
        .core_fiq   (core_fiq)
    );

    int            compared   = 0;
    int            mismatched = 0;
    int            cyc        = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    task automatic note(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL R10 watchdog actual=%0d expected<=20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    // Monitor: compare every returned read against the queue head
    logic [DW-1:0] mon_exp;
    string         mon_tag;
    always @(negedge clk) begin
        if (rst_n === 1'b1 && bus_rvalid === 1'b1) begin
            if (exp_q.size() == 0) begin
                note(1'b0, "R10 read data with no request", bus_rdata, '0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                note(bus_rdata === mon_exp, mon_tag, bus_rdata, mon_exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic chk_out(input logic [3:0] ei, input logic [3:0] ef, input string tag);
        note(core_irq === ei, {tag, " irq"}, 32'(core_irq), 32'(ei));
        note(core_fiq === ef, {tag, " fiq"}, 32'(core_fiq), 32'(ef));
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        timer_lvl = '0; mbox_lvl = '0; periph_lvl = 1'b0; perf_lvl = '0;
        berr_lvl = 1'b0; ltmr_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset state
        chk_out(4'h0, 4'h0, "R1 reset lines");
        rd(8'h00, 32'h0, "R1 control reset");
        rd(8'h08, 32'h0, "R1 prescaler reset");
        rd(8'h0C, 32'h0, "R1 route reset");
        rd(8'h10, 32'h0, "R1 perf enables reset");
        for (int c = 0; c < NCORE; c++) rd(AW'(8'h40 + 4 * c), 32'h0, "R1 timer config reset");
        rd(8'h60, 32'h0, "R1 pending idle");

        // R2: plain storage words
        wr(8'h08, 32'h8000_0000);
        wr(8'h00, 32'h1234_5678);
        rd(8'h08, 32'h8000_0000, "R2 prescaler readback");
        rd(8'h00, 32'h1234_5678, "R2 control readback");

        // R3: core 1 timer 2 to IRQ, timer 0 to FIQ, upper bits dropped
        wr(8'h44, 32'hFFFF_0014);
        rd(8'h44, 32'h0000_0014, "R3 timer config width");
        timer_lvl = 16'h0040;
        settle();
        chk_out(4'b0010, 4'b0000, "R3 core1 timer2 IRQ");
        timer_lvl = 16'h0010;
        settle();
        chk_out(4'b0000, 4'b0010, "R3 core1 timer0 FIQ");
        timer_lvl = 16'h0054;   // plus core0 timer2, core0 unconfigured
        settle();
        chk_out(4'b0010, 4'b0010, "R3 core0 timer stays masked");

        // R4: zero write masks all timers of the core
        wr(8'h44, 32'h0);
        settle();
        chk_out(4'b0000, 4'b0000, "R4 zero config masks timers");
        rd(8'h44, 32'h0, "R4 timer config cleared");
        timer_lvl = '0;

        // R5: shared route IRQ to core 2, FIQ to core 3, both enabled
        wr(8'h0C, 32'hFFFF_FF3E);
        rd(8'h0C, 32'h0000_003E, "R5 route readback");
        periph_lvl = 1'b1;
        settle();
        chk_out(4'b0100, 4'b1000, "R5 shared to core2 IRQ core3 FIQ");
        wr(8'h0C, 32'h0000_001C);
        settle();
        chk_out(4'b0001, 4'b0000, "R5 IRQ to core0 FIQ disabled");
        wr(8'h0C, 32'h0);
        settle();
        chk_out(4'b0000, 4'b0000, "R5 both routes disabled");
        periph_lvl = 1'b0;

        // R6: write-1 set / clear of monitor enables
        wr(8'h10, 32'h0000_0021);
        perf_lvl = 4'hF;
        settle();
        chk_out(4'b0001, 4'b0010, "R6 set core0 IRQ core1 FIQ");
        wr(8'h10, 32'h0000_0004);
        settle();
        chk_out(4'b0101, 4'b0010, "R6 set ORs in");
        rd(8'h10, 32'h0000_0025, "R6 set address readback");
        rd(8'h14, 32'h0000_0025, "R6 clear address readback");
        wr(8'h14, 32'h0000_0001);
        settle();
        chk_out(4'b0100, 4'b0010, "R6 clear only written ones");
        rd(8'h10, 32'h0000_0024, "R6 after clear");
        wr(8'h14, 32'h0000_00FF);
        settle();
        chk_out(4'b0000, 4'b0000, "R6 clear all");
        perf_lvl = '0;

        // R8: mailbox to IRQ only
        mbox_lvl = 16'h4000;
        settle();
        chk_out(4'b1000, 4'b0000, "R8 core3 mailbox2 IRQ");
        mbox_lvl = '0;

        // R7: pending word layout under a mixed pattern
        timer_lvl = 16'hA5C3; mbox_lvl = 16'h1248; periph_lvl = 1'b1;
        perf_lvl = 4'b0110; berr_lvl = 1'b1; ltmr_lvl = 1'b0;
        settle();
        chk_out(4'b1111, 4'b0000, "R8 every core mailbox IRQ");
        rd(8'h60, 32'h0000_0583, "R7 core0 pending");
        rd(8'h64, 32'h0000_074C, "R7 core1 pending");
        rd(8'h68, 32'h0000_0725, "R7 core2 pending");
        rd(8'h6C, 32'h0000_051A, "R7 core3 pending");
        berr_lvl = 1'b0; ltmr_lvl = 1'b1;
        settle();
        rd(8'h60, 32'h0000_0983, "R7 core0 local timer bit");

        // R9: pending and unmapped writes ignored, unmapped reads zero
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h41, 32'h0000_00FF);
        rd(8'h60, 32'h0000_0983, "R9 pending write ignored");
        rd(8'h04, 32'h0, "R9 unmapped read 0x04");
        rd(8'h50, 32'h0, "R9 unmapped read 0x50");
        rd(8'h70, 32'h0, "R9 unmapped read 0x70");
        rd(8'h40, 32'h0, "R9 misaligned write left timer config");
        rd(8'h00, 32'h1234_5678, "R9 control untouched");
        rd(8'h08, 32'h8000_0000, "R9 prescaler untouched");
        chk_out(4'b1111, 4'b0000, "R9 lines unchanged");
        timer_lvl = '0; mbox_lvl = '0; periph_lvl = 1'b0; perf_lvl = '0; ltmr_lvl = 1'b0;

        // R10: back-to-back reads, then idle valid
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        exp_q.push_back(32'h1234_5678); tag_q.push_back("R10 first back-to-back read");
        @(negedge clk);
        bus_addr = 8'h08;
        exp_q.push_back(32'h8000_0000); tag_q.push_back("R10 second back-to-back read");
        @(negedge clk);
        bus_sel = 1'b0;
        settle();
        settle();
        note(bus_rvalid === 1'b0, "R10 valid low when idle", 32'(bus_rvalid), 32'h0);
        note(exp_q.size() == 0, "R10 all reads returned", 32'(exp_q.size()), 32'h0);

        summary();
        $finish;
    end

endmodule